// File: doc/BRIEF.md
# Banked Local Memory with Address Translation

This block is the local scratch memory of a compute accelerator. A single host port, driven by the DMA side, sees every bank together as one flat word-addressed space. The processing elements see the same storage as several independent banks, each with its own read/write port. This lets several work-items fetch or store in the same cycle without contending for one port.

A translation stage between the host port and the banks turns each host word address into a bank number and a word offset. In linear mode each bank holds one contiguous slice of the host space. In paired mode, consecutive 128-bit blocks (four 32-bit words) of each half of the host space alternate between two banks. This gives two work-items equal shares of their input and output data. Both mappings only reorder address lines. The mode is a static configuration input. A host access and a processing-element access to the same bank in the same cycle are resolved in favour of the host, and the processing element is held off through that bank's ready signal.

Top module: `banked_local_mem`

## Requirements
- R1: With `xl_mode`=0 (linear), host word address A (0..63) selects bank A[5:4] and offset A[3:0]. A word the host writes is returned by that bank's processing-element port at that offset.
- R2: A host read returns its word on `h_rdata` in the clock cycle after the read is presented. Reads may be issued back to back, one per cycle.
- R3: With `xl_mode`=1 (paired), host address A selects bank {A[2], A[5]} and offset {A[4:3], A[1:0]}. Within the lower half, 4-word blocks therefore alternate between bank 0 and bank 2. Within the upper half, they alternate between bank 1 and bank 3.
- R4: In paired mode, host addresses 0..31 fill all 16 offsets of bank 0 and all 16 offsets of bank 2, each exactly once.
- R5: Processing-element ports work independently. All four banks accessed in one cycle each return their own word one cycle later. A bank that the host is not addressing never drops its ready signal.
- R6: When the host and a processing element address the same bank in one cycle, only that bank's `pe_ready` bit is low in that cycle and the processing-element access is not performed. The host read returns the word stored before that cycle. The processing-element access completes in the first cycle without a host access to that bank.
- R7: A host address of 64 or more (A[6]=1) is out of range. A write there changes no bank, a read there returns zero, and such an access stalls no processing-element port.
- R8: After reset, `h_rdata` and every lane of `pe_rdata` are zero, and every `pe_ready` bit is 1.
- R9: A word written through a processing-element port is returned by a host read at the host address that maps to that bank and offset.
- R10: Changing `xl_mode` changes only the mapping. Stored words stay in place, and a later host read uses the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_mode | input | 1 | Translation mode: 0 linear, 1 paired |
| h_en | input | 1 | Host access strobe |
| h_we | input | 1 | Host write when 1, read when 0 |
| h_addr | input | 7 | Host word address; bit 6 set means out of range |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after the read |
| pe_en | input | 4 | Per-bank processing-element access strobe |
| pe_we | input | 4 | Per-bank processing-element write enable |
| pe_addr | input | 16 | Per-bank word offset, 4 bits per bank, bank 0 in the low bits |
| pe_wdata | input | 128 | Per-bank write data, 32 bits per bank |
| pe_rdata | output | 128 | Per-bank read data, 32 bits per bank |
| pe_ready | output | 4 | Per-bank grant; low when the host owns the bank this cycle |

## Verification
The hardest situation to reach from the ports is a same-cycle collision in which the host reads a word while a processing element tries to overwrite that same word. At the same moment, another bank must keep running. The stimulus first fills every bank through the host, so that every stored word is known. It then raises a host read, a processing-element write to the same bank and offset, and a processing-element read on an unrelated bank, all in one cycle. It checks the ready vector within that cycle, the old word returned to the host, and the deferred write landing one cycle later. Mapping is checked by filling memory in one mode, reading it through the bank ports and through the host, and then re-reading after a mode change.

// File: rtl/bkm_pkg.sv
package bkm_pkg;
  typedef enum logic {
    XL_LINEAR = 1'b0,
    XL_PAIRED = 1'b1
  } xl_mode_e;
endpackage

// File: rtl/bkm_addr_xlate.sv
module bkm_addr_xlate
  import bkm_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 16,
  parameter int DATA_W     = 32,
  parameter int BLOCK_BITS = 128,
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int OFF_W   = $clog2(BANK_DEPTH),
  localparam int LIN_W   = BANK_W + OFF_W,
  localparam int HADDR_W = LIN_W + 1,
  localparam int WB      = $clog2(BLOCK_BITS / DATA_W)
) (
  input  xl_mode_e             mode,
  input  logic [HADDR_W-1:0]   addr,
  output logic                 in_range,
  output logic [BANK_W-1:0]    bank,
  output logic [OFF_W-1:0]     offset
);

  // linear: upper address lines pick the bank, lower lines the offset
  function automatic logic [LIN_W-1:0] linear_map(input logic [LIN_W-1:0] lin);
    return lin;
  endfunction

  // paired: block-index bit 0 becomes bank MSB; the half-select bit drops
  // into the low bank bits; the remaining block bits and word bits form the offset
  function automatic logic [LIN_W-1:0] paired_map(input logic [LIN_W-1:0] lin);
    return {lin[WB], lin[LIN_W-1:OFF_W+1], lin[OFF_W:WB+1], lin[WB-1:0]};
  endfunction

  logic [LIN_W-1:0] lin;
  assign lin = addr[LIN_W-1:0];

  always_comb begin
    in_range = ~addr[HADDR_W-1];
    if (mode == XL_PAIRED) {bank, offset} = paired_map(lin);
    else                   {bank, offset} = linear_map(lin);
  end

endmodule

// File: rtl/bkm_bank.sv
module bkm_bank #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              pe_en,
  input  logic              pe_we,
  input  logic [OFF_W-1:0]  pe_off,
  input  logic [DATA_W-1:0] pe_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pe_ready
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              port_en;
  logic              port_we;
  logic [OFF_W-1:0]  port_off;
  logic [DATA_W-1:0] port_wd;

  // host owns the single port whenever it addresses this bank
  assign pe_ready = ~host_sel;

  always_comb begin
    if (host_sel) begin
      port_en  = 1'b1;
      port_we  = host_we;
      port_off = host_off;
      port_wd  = host_wdata;
    end else begin
      port_en  = pe_en;
      port_we  = pe_we;
      port_off = pe_off;
      port_wd  = pe_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (port_en && port_we) mem[port_off] <= port_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rdata <= '0;
    else if (port_en && !port_we) rdata <= mem[port_off];
  end

endmodule

// File: rtl/banked_local_mem.sv
module banked_local_mem
  import bkm_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 16,
  parameter int DATA_W     = 32,
  parameter int BLOCK_BITS = 128,
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int OFF_W   = $clog2(BANK_DEPTH),
  localparam int LIN_W   = BANK_W + OFF_W,
  localparam int HADDR_W = LIN_W + 1,
  localparam int WB      = $clog2(BLOCK_BITS / DATA_W)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        xl_mode,
  input  logic                        h_en,
  input  logic                        h_we,
  input  logic [HADDR_W-1:0]          h_addr,
  input  logic [DATA_W-1:0]           h_wdata,
  output logic [DATA_W-1:0]           h_rdata,
  input  logic [NUM_BANKS-1:0]        pe_en,
  input  logic [NUM_BANKS-1:0]        pe_we,
  input  logic [NUM_BANKS*OFF_W-1:0]  pe_addr,
  input  logic [NUM_BANKS*DATA_W-1:0] pe_wdata,
  output logic [NUM_BANKS*DATA_W-1:0] pe_rdata,
  output logic [NUM_BANKS-1:0]        pe_ready
);

  xl_mode_e          mode_e;
  logic              xl_in_range;
  logic [BANK_W-1:0] xl_bank;
  logic [OFF_W-1:0]  xl_off;
  logic [NUM_BANKS-1:0] host_sel;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];
  logic [BANK_W-1:0] hbank_q;
  logic              hzero_q;

  assign mode_e = xl_mode_e'(xl_mode);

  bkm_addr_xlate #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_DEPTH(BANK_DEPTH),
    .DATA_W    (DATA_W),
    .BLOCK_BITS(BLOCK_BITS)
  ) u_xlate (
    .mode    (mode_e),
    .addr    (h_addr),
    .in_range(xl_in_range),
    .bank    (xl_bank),
    .offset  (xl_off)
  );

  // R3: in paired mode the bank MSB follows the 128-bit block parity
  a_r3_paired_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en && xl_mode && xl_in_range) |-> (xl_bank[BANK_W-1] == h_addr[WB]));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign host_sel[b] = h_en && xl_in_range && (xl_bank == BANK_W'(b));

    bkm_bank #(
      .DEPTH (BANK_DEPTH),
      .DATA_W(DATA_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_sel  (host_sel[b]),
      .host_we   (h_we),
      .host_off  (xl_off),
      .host_wdata(h_wdata),
      .pe_en     (pe_en[b]),
      .pe_we     (pe_we[b]),
      .pe_off    (pe_addr[b*OFF_W +: OFF_W]),
      .pe_wdata  (pe_wdata[b*DATA_W +: DATA_W]),
      .rdata     (bank_rd[b]),
      .pe_ready  (pe_ready[b])
    );

    assign pe_rdata[b*DATA_W +: DATA_W] = bank_rd[b];
  end

  // R6: the host touches one bank at most, so at most one lane stalls
  a_r6_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pe_ready));

  // R7: an out-of-range host access leaves every lane granted
  a_r7_oor_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en && h_addr[HADDR_W-1]) |-> (pe_ready == '1));

  // host read return path: remember which bank answers, or force zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hbank_q <= '0;
      hzero_q <= 1'b1;
    end else if (h_en && !h_we) begin
      hbank_q <= xl_bank;
      hzero_q <= ~xl_in_range;
    end
  end

  assign h_rdata = hzero_q ? '0 : bank_rd[hbank_q];

  // R7: out-of-range read returns zero on the next cycle
  a_r7_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en && !h_we && h_addr[HADDR_W-1]) |=> (h_rdata == '0));

endmodule

// File: tb/banked_local_mem_bench.sv
`timescale 1ns/1ps
module banked_local_mem_bench;
  localparam int NB = 4, DEPTH = 16, DW = 32, OW = 4, AW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, xl_mode, h_en, h_we;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wdata, h_rdata;
  logic [NB-1:0] pe_en, pe_we, pe_ready;
  logic [NB*OW-1:0] pe_addr;
  logic [NB*DW-1:0] pe_wdata, pe_rdata;

  banked_local_mem u_banked_local_mem (
    .clk(clk), .rst_n(rst_n), .xl_mode(xl_mode), .h_en(h_en), .h_we(h_we),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .pe_en(pe_en),
    .pe_we(pe_we), .pe_addr(pe_addr), .pe_wdata(pe_wdata), .pe_rdata(pe_rdata),
    .pe_ready(pe_ready)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mdl [NB][DEPTH];
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic rd_issue = 1'b0, rd_q = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench-side mapping written as arithmetic on the block index
  function automatic void map(input int a, input bit paired, output int b, output int o);
    int r, blk;
    if (!paired) begin
      b = a / DEPTH; o = a % DEPTH;
    end else begin
      r = a % (2*DEPTH); blk = r / 4;
      b = (blk % 2) * (NB/2) + a / (2*DEPTH);
      o = (blk / 2) * 4 + r % 4;
    end
  endfunction

  function automatic logic [DW-1:0] pat1(input int a);
    return 32'hB100_0000 + DW'(a) * 32'h0001_0003;
  endfunction
  function automatic logic [DW-1:0] pat2(input int a);
    return 32'hC200_0000 ^ (DW'(a) * 32'h0000_0105);
  endfunction

  // scoreboard monitor: host read results, one cycle after issue
  always @(posedge clk) rd_q <= rd_issue;
  always @(negedge clk) begin
    logic [DW-1:0] e;
    string t;
    if (rd_q) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, h_rdata, e);
    end
  end

  task automatic host_wr(input int a, input logic [DW-1:0] d);
    int b, o;
    h_en = 1'b1; h_we = 1'b1; h_addr = AW'(a); h_wdata = d;
    if (a < NB*DEPTH) begin
      map(a, xl_mode, b, o);
      mdl[b][o] = d;
    end
    @(negedge clk);
    h_en = 1'b0; h_we = 1'b0;
  endtask

  task automatic host_rd(input int a, input string tag);
    int b, o;
    h_en = 1'b1; h_we = 1'b0; h_addr = AW'(a);
    if (a < NB*DEPTH) begin
      map(a, xl_mode, b, o);
      exp_q.push_back(mdl[b][o]);
    end else exp_q.push_back('0);
    tag_q.push_back(tag);
    rd_issue = 1'b1;
    @(negedge clk);
    h_en = 1'b0; rd_issue = 1'b0;
  endtask

  task automatic pe_rd(input int b, input int o, input logic [DW-1:0] exp, input string tag);
    pe_en[b] = 1'b1; pe_we[b] = 1'b0; pe_addr[b*OW +: OW] = OW'(o);
    @(negedge clk);
    chk(tag, pe_rdata[b*DW +: DW], exp);
    pe_en[b] = 1'b0;
  endtask

  task automatic pe_wr(input int b, input int o, input logic [DW-1:0] d);
    pe_en[b] = 1'b1; pe_we[b] = 1'b1; pe_addr[b*OW +: OW] = OW'(o);
    pe_wdata[b*DW +: DW] = d;
    @(negedge clk);
    pe_en[b] = 1'b0; pe_we[b] = 1'b0;
    mdl[b][o] = d;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; xl_mode = 1'b0; h_en = 1'b0; h_we = 1'b0; h_addr = '0;
    h_wdata = '0; pe_en = '0; pe_we = '0; pe_addr = '0; pe_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 h_rdata", h_rdata, '0);
    chk("R8 pe_ready", {28'b0, pe_ready}, 32'hF);
    for (int b = 0; b < NB; b++) chk("R8 pe_rdata", pe_rdata[b*DW +: DW], '0);

    // R1 linear fill, read through bank ports
    xl_mode = 1'b0;
    for (int a = 0; a < NB*DEPTH; a++) host_wr(a, pat1(a));
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < DEPTH; o++) pe_rd(b, o, pat1(b*DEPTH + o), "R1");

    // R5 all lanes at once, different offsets per lane
    for (int o = 0; o < DEPTH; o++) begin
      pe_en = '1; pe_we = '0;
      for (int b = 0; b < NB; b++) pe_addr[b*OW +: OW] = OW'((o + b) % DEPTH);
      #1 chk("R5 ready", {28'b0, pe_ready}, 32'hF);
      @(negedge clk);
      for (int b = 0; b < NB; b++) chk("R5", pe_rdata[b*DW +: DW], mdl[b][(o + b) % DEPTH]);
      pe_en = '0;
    end

    // R2 back-to-back host reads
    for (int a = 0; a < NB*DEPTH; a += 5) host_rd(a, "R2");

    // R7 out-of-range write with a lane active, then reads
    h_en = 1'b1; h_we = 1'b1; h_addr = AW'(69); h_wdata = 32'hDEAD_BEEF;
    pe_en[0] = 1'b1; pe_we[0] = 1'b0; pe_addr[0 +: OW] = OW'(3);
    #1 chk("R7 no stall", {28'b0, pe_ready}, 32'hF);
    @(negedge clk);
    chk("R7 lane read", pe_rdata[0 +: DW], mdl[0][3]);
    h_en = 1'b0; h_we = 1'b0; pe_en = '0;
    host_rd(5, "R7 alias untouched");
    host_rd(69, "R7 oor read");
    host_rd(127, "R7 oor read");

    // R9 lane write seen by host
    pe_wr(3, 7, 32'h5A5A_0F0F);
    host_rd(3*DEPTH + 7, "R9");

    // R6 collision: host read bank2 off9, lane2 writes same word, lane0 reads
    h_en = 1'b1; h_we = 1'b0; h_addr = AW'(41);
    exp_q.push_back(mdl[2][9]); tag_q.push_back("R6 host sees old word");
    rd_issue = 1'b1;
    pe_en = 4'b0101; pe_we = 4'b0100;
    pe_addr[2*OW +: OW] = OW'(9); pe_wdata[2*DW +: DW] = 32'hC0FF_EE01;
    pe_addr[0 +: OW] = OW'(1);
    #1 chk("R6 ready", {28'b0, pe_ready}, 32'hB);
    @(negedge clk);
    h_en = 1'b0; rd_issue = 1'b0;
    chk("R5 lane0 during collision", pe_rdata[0 +: DW], mdl[0][1]);
    #1 chk("R6 released", {28'b0, pe_ready}, 32'hF);
    @(negedge clk);
    pe_en = '0; pe_we = '0;
    mdl[2][9] = 32'hC0FF_EE01;
    host_rd(41, "R6 deferred write");
    pe_rd(2, 9, 32'hC0FF_EE01, "R6 lane view");

    // R3 / R4 paired mode
    xl_mode = 1'b1;
    @(negedge clk);
    for (int a = 0; a < NB*DEPTH; a++) host_wr(a, pat2(a));
    pe_rd(0, 0, pat2(0), "R3");
    pe_rd(2, 0, pat2(4), "R3");
    pe_rd(0, 4, pat2(8), "R3");
    pe_rd(2, 15, pat2(31), "R3");
    pe_rd(3, 0, pat2(36), "R3");
    pe_rd(1, 5, pat2(41), "R3");
    for (int o = 0; o < DEPTH; o++) begin
      pe_rd(0, o, mdl[0][o], "R4 bank0");
      pe_rd(2, o, mdl[2][o], "R4 bank2");
      pe_rd(1, o, mdl[1][o], "R3 bank1");
      pe_rd(3, o, mdl[3][o], "R3 bank3");
    end
    for (int a = 0; a < NB*DEPTH; a++) host_rd(a, "R3 host round trip");

    // R10 mode change keeps contents, remaps view
    xl_mode = 1'b0;
    @(negedge clk);
    host_rd(4, "R10");
    host_rd(36, "R10");
    chk("R10 linear addr 4", mdl[0][4], pat2(8));

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule